// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block holds the architectural integer registers of a 32-bit core that runs in one of seven operating modes. Each of the sixteen architectural indices maps to a physical storage slot. The mapping depends on the current mode. The low indices are one common set. The stack pointer and link register have a private copy in every exception mode. The fast-interrupt mode goes further and has private copies of indices 8 through 14. The program counter lives outside the block: reads of index 15 return a supplied value, and writes to it are flagged rather than stored.

The datapath uses two combinational read ports and one write port, all keyed by a 4-bit index under the current mode. An exception sequencer has a separate side port. Through it, the sequencer deposits a return address into the link register of any target mode, whatever mode is current. It can also read and write the saved-status register of that target mode. Thirty general slots and five saved-status slots are stored. The single current-status register is held by the surrounding core.

Top module: `regfile_banked`

## Requirements
- R1: Indices 0 to 7 name the same physical registers in every mode.
- R2: In fast-interrupt mode (mode code 1), indices 8 to 14 name registers private to that mode, and writes made there are not visible from any other mode.
- R3: Interrupt (2), supervisor (3), abort (4) and undefined (5) modes each have a private stack pointer (index 13) and link register (index 14). Their indices 8 to 12 are the user-mode registers.
- R4: System mode (code 6) and the unused code 7 see exactly the user-mode (code 0) registers at every index.
- R5: A read of index 15 returns `pc_val`. A port write to index 15 raises `pc_wr` in the same cycle and changes no stored register.
- R6: Reads are combinational. A read of a register being written in the same cycle returns the old value, and the new value appears from the next cycle on.
- R7: A sequencer link-register write stores into index 14 of `seq_mode`, independent of the current `mode`.
- R8: When a port write and a sequencer link-register write hit the same physical register in one cycle, the sequencer data is kept. Writes to different registers in one cycle both take effect.
- R9: Modes 1 to 5 each own one saved-status register. `seq_spsr_rdata` combinationally shows the one selected by `seq_mode`, and a write updates it from the next cycle on.
- R10: With `seq_mode` set to user or system, `seq_spsr_rdata` is zero and a saved-status write changes nothing.
- R11: Reset (active-low `rst_n`) clears every stored register to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 3 | Current operating mode |
| pc_val | input | 32 | Program counter value returned for index 15 |
| rd_a_idx | input | 4 | Read port A index |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 4 | Read port B index |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | Port write enable |
| wr_idx | input | 4 | Port write index |
| wr_data | input | 32 | Port write data |
| pc_wr | output | 1 | Port write targets index 15 |
| seq_mode | input | 3 | Target mode of the sequencer side port |
| seq_lr_we | input | 1 | Sequencer link-register write enable |
| seq_lr_data | input | 32 | Sequencer link-register write data |
| seq_spsr_we | input | 1 | Saved-status write enable |
| seq_spsr_wdata | input | 32 | Saved-status write data |
| seq_spsr_rdata | output | 32 | Saved-status read data for `seq_mode` |

## Verification
The assertions are checked on every cycle. They cover the following:
- a port write reads back on the next cycle under a stable mode;
- a sequencer link-register write survives a same-cycle port write to the same slot;
- a write to index 15 leaves reads unchanged;
- saved-status writes round-trip in exception modes and are dropped in user or system mode.

The bench scenarios cover what needs a history of prior writes, because cross-mode isolation can only be seen that way. They check that values written in one mode are or are not seen from another, that system mode aliases user mode, that a same-cycle read returns the old value, and that reset clears everything.

// File: rtl/rf_bank_pkg.sv
package rf_bank_pkg;

    localparam logic [2:0] MD_USER   = 3'd0;
    localparam logic [2:0] MD_FAST   = 3'd1;
    localparam logic [2:0] MD_IRQ    = 3'd2;
    localparam logic [2:0] MD_SUPV   = 3'd3;
    localparam logic [2:0] MD_ABORT  = 3'd4;
    localparam logic [2:0] MD_UNDEF  = 3'd5;
    localparam logic [2:0] MD_SYSTEM = 3'd6;

    localparam int SHARED_LOW  = 8;                  // indices always common
    localparam int FAST_FIRST  = 8;                  // first index banked in fast mode
    localparam int FAST_COUNT  = 7;                  // indices 8..14
    localparam int EXC_MODES   = 4;                  // irq, supv, abort, undef
    localparam int USER_SLOTS  = 15;                 // indices 0..14
    localparam int FAST_BASE   = USER_SLOTS;
    localparam int EXC_BASE    = FAST_BASE + FAST_COUNT;
    localparam int NUM_SLOTS   = EXC_BASE + 2 * EXC_MODES;   // 30
    localparam int SLOT_W      = $clog2(NUM_SLOTS);
    localparam int NUM_SAVED   = 5;
    localparam int SAVED_W     = $clog2(NUM_SAVED);
    localparam logic [3:0] IDX_SP = 4'd13;
    localparam logic [3:0] IDX_LR = 4'd14;
    localparam logic [3:0] IDX_PC = 4'd15;

    function automatic logic [SLOT_W-1:0] phys_slot(input logic [3:0] idx,
                                                    input logic [2:0] md);
        int s;
        s = int'(idx);
        if (idx == IDX_PC) begin
            s = 0;
        end else if (int'(idx) >= SHARED_LOW) begin
            if (md == MD_FAST) begin
                s = FAST_BASE + int'(idx) - FAST_FIRST;
            end else if (md >= MD_IRQ && md <= MD_UNDEF && idx >= IDX_SP) begin
                s = EXC_BASE + 2 * (int'(md) - int'(MD_IRQ)) + (int'(idx) - int'(IDX_SP));
            end
        end
        return SLOT_W'(s);
    endfunction

    function automatic logic owns_saved(input logic [2:0] md);
        return (md >= MD_FAST) && (md <= MD_UNDEF);
    endfunction

    function automatic logic [SAVED_W-1:0] saved_slot(input logic [2:0] md);
        int s;
        s = owns_saved(md) ? int'(md) - int'(MD_FAST) : 0;
        return SAVED_W'(s);
    endfunction

endpackage

// File: rtl/rf_slot_decode.sv
module rf_slot_decode
    import rf_bank_pkg::*;
(
    input  logic [3:0]        idx,
    input  logic [2:0]        md,
    output logic [SLOT_W-1:0] slot,
    output logic              is_pc
);
    always_comb begin
        is_pc = (idx == IDX_PC);
        slot  = phys_slot(idx, md);
    end
endmodule

// File: rtl/rf_gpr_store.sv
module rf_gpr_store
    import rf_bank_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              port_we,
    input  logic [SLOT_W-1:0] port_slot,
    input  logic [XLEN-1:0]   port_data,
    input  logic              seq_we,
    input  logic [SLOT_W-1:0] seq_slot,
    input  logic [XLEN-1:0]   seq_data,
    input  logic [SLOT_W-1:0] rd_slot_a,
    input  logic [SLOT_W-1:0] rd_slot_b,
    output logic [XLEN-1:0]   rd_data_a,
    output logic [XLEN-1:0]   rd_data_b
);
    typedef struct packed {
        logic [NUM_SLOTS-1:0][XLEN-1:0] regs;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (port_we) st_d.regs[port_slot] = port_data;
        if (seq_we)  st_d.regs[seq_slot]  = seq_data;   // sequencer applied last
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data_a = st_q.regs[rd_slot_a];
    assign rd_data_b = st_q.regs[rd_slot_b];

    p_seq_priority_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_we && port_we && seq_slot == port_slot)
        |=> st_q.regs[$past(seq_slot)] == $past(seq_data));

    p_reset_clear_r11: assert property (@(posedge clk)
        $past(!rst_n) |-> st_q == '0);
endmodule

// File: rtl/rf_saved_bank.sv
module rf_saved_bank
    import rf_bank_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [2:0]      sel_mode,
    input  logic            we,
    input  logic [XLEN-1:0] wdata,
    output logic [XLEN-1:0] rdata
);
    typedef struct packed {
        logic [NUM_SAVED-1:0][XLEN-1:0] psr;
    } saved_t;

    saved_t sv_d, sv_q;
    logic   sel_ok;

    always_comb begin
        sel_ok = owns_saved(sel_mode);
        sv_d   = sv_q;
        if (we && sel_ok) sv_d.psr[saved_slot(sel_mode)] = wdata;
        rdata  = sel_ok ? sv_q.psr[saved_slot(sel_mode)] : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sv_q <= '0;
        else        sv_q <= sv_d;
    end

    p_saved_roundtrip_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (we && owns_saved(sel_mode))
        |=> ($stable(sel_mode) -> rdata == $past(wdata)));

    p_user_saved_dropped_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !owns_saved(sel_mode)) |=> sv_q == $past(sv_q));
endmodule

// File: rtl/regfile_banked.sv
module regfile_banked
    import rf_bank_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [2:0]      mode,
    input  logic [XLEN-1:0] pc_val,
    input  logic [3:0]      rd_a_idx,
    output logic [XLEN-1:0] rd_a_data,
    input  logic [3:0]      rd_b_idx,
    output logic [XLEN-1:0] rd_b_data,
    input  logic            wr_en,
    input  logic [3:0]      wr_idx,
    input  logic [XLEN-1:0] wr_data,
    output logic            pc_wr,
    input  logic [2:0]      seq_mode,
    input  logic            seq_lr_we,
    input  logic [XLEN-1:0] seq_lr_data,
    input  logic            seq_spsr_we,
    input  logic [XLEN-1:0] seq_spsr_wdata,
    output logic [XLEN-1:0] seq_spsr_rdata
);
    localparam int NLOOK  = 4;       // read A, read B, write, sequencer LR
    localparam int LK_RA  = 0;
    localparam int LK_RB  = 1;
    localparam int LK_WR  = 2;
    localparam int LK_SEQ = 3;

    logic [NLOOK-1:0][3:0]        lk_idx;
    logic [NLOOK-1:0][2:0]        lk_mode;
    logic [NLOOK-1:0][SLOT_W-1:0] lk_slot;
    logic [NLOOK-1:0]             lk_pc;
    logic [XLEN-1:0]              gpr_a, gpr_b;

    always_comb begin
        lk_idx[LK_RA]   = rd_a_idx;  lk_mode[LK_RA]  = mode;
        lk_idx[LK_RB]   = rd_b_idx;  lk_mode[LK_RB]  = mode;
        lk_idx[LK_WR]   = wr_idx;    lk_mode[LK_WR]  = mode;
        lk_idx[LK_SEQ]  = IDX_LR;    lk_mode[LK_SEQ] = seq_mode;
    end

    for (genvar g = 0; g < NLOOK; g++) begin : g_look
        rf_slot_decode u_dec (
            .idx   (lk_idx[g]),
            .md    (lk_mode[g]),
            .slot  (lk_slot[g]),
            .is_pc (lk_pc[g])
        );
    end

    rf_gpr_store #(.XLEN(XLEN)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .port_we   (wr_en && !lk_pc[LK_WR]),
        .port_slot (lk_slot[LK_WR]),
        .port_data (wr_data),
        .seq_we    (seq_lr_we),
        .seq_slot  (lk_slot[LK_SEQ]),
        .seq_data  (seq_lr_data),
        .rd_slot_a (lk_slot[LK_RA]),
        .rd_slot_b (lk_slot[LK_RB]),
        .rd_data_a (gpr_a),
        .rd_data_b (gpr_b)
    );

    rf_saved_bank #(.XLEN(XLEN)) u_saved (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_mode (seq_mode),
        .we       (seq_spsr_we),
        .wdata    (seq_spsr_wdata),
        .rdata    (seq_spsr_rdata)
    );

    always_comb begin
        rd_a_data = lk_pc[LK_RA] ? pc_val : gpr_a;
        rd_b_data = lk_pc[LK_RB] ? pc_val : gpr_b;
        pc_wr     = wr_en && lk_pc[LK_WR];
    end

    p_wr_then_rd_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx != IDX_PC && !seq_lr_we && rd_a_idx == wr_idx)
        |=> (($stable(mode) && $stable(rd_a_idx)) -> rd_a_data == $past(wr_data)));

    p_seq_lr_target_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_lr_we && rd_a_idx == IDX_LR && mode == seq_mode)
        |=> (($stable(mode) && $stable(rd_a_idx)) -> rd_a_data == $past(seq_lr_data)));

    p_pc_write_dropped_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == IDX_PC && !seq_lr_we && rd_a_idx != IDX_PC)
        |=> (($stable(mode) && $stable(rd_a_idx)) -> rd_a_data == $past(rd_a_data)));
endmodule

// File: tb/regfile_banked_test.sv
module regfile_banked_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  mode = '0;
    logic [31:0] pc_val = '0;
    logic [3:0]  rd_a_idx = '0, rd_b_idx = '0;
    logic [31:0] rd_a_data, rd_b_data;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_idx = '0;
    logic [31:0] wr_data = '0;
    logic        pc_wr;
    logic [2:0]  seq_mode = '0;
    logic        seq_lr_we = 1'b0;
    logic [31:0] seq_lr_data = '0;
    logic        seq_spsr_we = 1'b0;
    logic [31:0] seq_spsr_wdata = '0;
    logic [31:0] seq_spsr_rdata;

    int applied = 0;
    int miscomp = 0;
    bit finished = 0;

    typedef struct {
        int          sel;     // 0 read A, 1 read B, 2 saved status, 3 pc_wr flag
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb[$];

    always #4 clk = ~clk;     // 125 MHz

    regfile_banked uut (
        .clk(clk), .rst_n(rst_n), .mode(mode), .pc_val(pc_val),
        .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .pc_wr(pc_wr),
        .seq_mode(seq_mode), .seq_lr_we(seq_lr_we), .seq_lr_data(seq_lr_data),
        .seq_spsr_we(seq_spsr_we), .seq_spsr_wdata(seq_spsr_wdata),
        .seq_spsr_rdata(seq_spsr_rdata)
    );

    // monitor: pops expectations and compares against live outputs
    initial begin
        forever begin
            item_t it;
            logic [31:0] act;
            wait (sb.size() != 0);
            it = sb.pop_front();
            case (it.sel)
                0: act = rd_a_data;
                1: act = rd_b_data;
                2: act = seq_spsr_rdata;
                default: act = {31'b0, pc_wr};
            endcase
            applied++;
            if (act !== it.exp) begin
                miscomp++;
                $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
            end
        end
    end

    task automatic push(input int sel, input logic [31:0] exp, input string tag);
        item_t it;
        it.sel = sel; it.exp = exp; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic wr(input logic [2:0] m, input logic [3:0] i, input logic [31:0] d);
        @(negedge clk);
        mode = m; wr_en = 1'b1; wr_idx = i; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] m, input logic [3:0] i,
                      input logic [31:0] exp, input string tag);
        @(negedge clk);
        mode = m; rd_a_idx = i; rd_b_idx = i;
        #1;
        push(0, exp, tag);
        push(1, exp, tag);
    endtask

    task automatic seq_lr(input logic [2:0] tm, input logic [31:0] d);
        @(negedge clk);
        seq_mode = tm; seq_lr_we = 1'b1; seq_lr_data = d;
        @(negedge clk);
        seq_lr_we = 1'b0;
    endtask

    task automatic spsr_wr(input logic [2:0] tm, input logic [31:0] d);
        @(negedge clk);
        seq_mode = tm; seq_spsr_we = 1'b1; seq_spsr_wdata = d;
        @(negedge clk);
        seq_spsr_we = 1'b0;
    endtask

    task automatic spsr_rd(input logic [2:0] tm, input logic [31:0] exp, input string tag);
        @(negedge clk);
        seq_mode = tm;
        #1;
        push(2, exp, tag);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            miscomp++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", applied, miscomp);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        // R11 reset state: stored registers and saved status read zero
        rd(3'd0, 4'd0, 32'h0, "R11 user r0 after reset");
        spsr_rd(3'd3, 32'h0, "R11 supv saved after reset");
        @(negedge clk); rst_n = 1'b1;
        rd(3'd4, 4'd14, 32'h0, "R11 abort lr after reset");

        for (int i = 0; i < 15; i++) wr(3'd0, 4'(i), 32'h1000_0000 + i);

        // R1 low indices common to all modes
        rd(3'd1, 4'd5, 32'h1000_0005, "R1 fast r5");
        rd(3'd5, 4'd7, 32'h1000_0007, "R1 undef r7");

        // R2 fast mode private 8..14
        for (int i = 8; i < 15; i++) wr(3'd1, 4'(i), 32'h2000_0000 + i);
        rd(3'd1, 4'd10, 32'h2000_000A, "R2 fast r10");
        rd(3'd0, 4'd10, 32'h1000_000A, "R2 user r10 untouched");
        rd(3'd2, 4'd10, 32'h1000_000A, "R2 irq r10 sees user");
        rd(3'd1, 4'd14, 32'h2000_000E, "R2 fast lr");

        // R3 exception modes bank sp/lr only
        wr(3'd2, 4'd13, 32'h3000_000D);
        wr(3'd3, 4'd13, 32'h4000_000D);
        rd(3'd2, 4'd13, 32'h3000_000D, "R3 irq sp");
        rd(3'd3, 4'd13, 32'h4000_000D, "R3 supv sp");
        rd(3'd0, 4'd13, 32'h1000_000D, "R3 user sp untouched");
        rd(3'd1, 4'd13, 32'h2000_000D, "R3 fast sp untouched");
        rd(3'd4, 4'd14, 32'h0,         "R3 abort lr still zero");
        wr(3'd3, 4'd9, 32'h4000_0009);
        rd(3'd0, 4'd9, 32'h4000_0009, "R3 supv r9 is user r9");

        // R4 system aliases user
        wr(3'd6, 4'd9, 32'h5000_0009);
        rd(3'd0, 4'd9, 32'h5000_0009, "R4 user sees system write");
        rd(3'd6, 4'd13, 32'h1000_000D, "R4 system sp is user sp");
        rd(3'd7, 4'd14, 32'h1000_000E, "R4 code 7 lr is user lr");

        // R5 program counter index
        pc_val = 32'hCAFE_0000;
        rd(3'd2, 4'd15, 32'hCAFE_0000, "R5 read pc");
        @(negedge clk);
        mode = 3'd0; wr_en = 1'b1; wr_idx = 4'd15; wr_data = 32'h0BAD_0BAD;
        #1; push(3, 32'h1, "R5 pc_wr flag");
        @(negedge clk); wr_en = 1'b0;
        #1; push(3, 32'h0, "R5 pc_wr low after");
        rd(3'd0, 4'd0, 32'h1000_0000, "R5 r0 untouched by pc write");
        rd(3'd1, 4'd8, 32'h2000_0008, "R5 fast r8 untouched by pc write");

        // R6 same-cycle read returns old value
        @(negedge clk);
        mode = 3'd0; rd_a_idx = 4'd3; rd_b_idx = 4'd3;
        wr_en = 1'b1; wr_idx = 4'd3; wr_data = 32'h0000_BEEF;
        #1; push(0, 32'h1000_0003, "R6 old value same cycle");
        @(negedge clk); wr_en = 1'b0;
        #1; push(0, 32'h0000_BEEF, "R6 new value next cycle");

        // R7 sequencer lr into another mode
        mode = 3'd0;
        seq_lr(3'd4, 32'hA000_0014);
        rd(3'd4, 4'd14, 32'hA000_0014, "R7 abort lr from sequencer");
        rd(3'd0, 4'd14, 32'h1000_000E, "R7 user lr untouched");

        // R8 precedence and independent writes
        @(negedge clk);
        mode = 3'd3; wr_en = 1'b1; wr_idx = 4'd14; wr_data = 32'h0000_0011;
        seq_mode = 3'd3; seq_lr_we = 1'b1; seq_lr_data = 32'h0000_0022;
        @(negedge clk);
        wr_idx = 4'd2; wr_data = 32'h0000_0033;
        seq_mode = 3'd2; seq_lr_data = 32'h0000_0044;
        @(negedge clk); wr_en = 1'b0; seq_lr_we = 1'b0;
        rd(3'd3, 4'd14, 32'h0000_0022, "R8 sequencer wins");
        rd(3'd2, 4'd14, 32'h0000_0044, "R8 seq write to irq lr");
        rd(3'd0, 4'd2, 32'h0000_0033, "R8 port write same cycle");

        // R9 saved status per mode
        spsr_wr(3'd3, 32'h0000_01D3);
        spsr_wr(3'd2, 32'h0000_00D2);
        spsr_rd(3'd3, 32'h0000_01D3, "R9 supv saved");
        spsr_rd(3'd2, 32'h0000_00D2, "R9 irq saved");
        spsr_rd(3'd1, 32'h0, "R9 fast saved untouched");

        // R10 user/system saved access
        spsr_wr(3'd0, 32'hFFFF_FFFF);
        spsr_wr(3'd6, 32'hEEEE_EEEE);
        spsr_rd(3'd0, 32'h0, "R10 user saved reads zero");
        spsr_rd(3'd6, 32'h0, "R10 system saved reads zero");
        spsr_rd(3'd3, 32'h0000_01D3, "R10 supv saved unchanged");
        spsr_rd(3'd5, 32'h0, "R10 undef saved unchanged");

        wait (sb.size() == 0);
        #1;
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", applied, miscomp);
        $finish;
    end
endmodule